// File: doc/BRIEF.md
# Store-and-Forward Frame Forwarding Filter

This block makes the forwarding decision for a switch frame after the frame has been fully received and written to the packet buffer. When a frame-end strobe arrives, the block reads the frame's status and decides whether the frame goes to one port, is flooded, or is discarded. The status it reads is the CRC result, the byte length, the ingress port, the lookup result (hit flag and port), the type field, the destination address and the trunk-group map. It returns a five-port destination mask, a drop flag and a 3-bit code that gives the reason for the drop.

A frame is forwarded only if it passes every qualification rule. Its CRC must be good. Its length must lie within the legal range, and the upper bound of that range is chosen by a configuration bit. It must not be a MAC control frame. On a lookup hit, the destination port must not be the ingress port, and it must not share a trunk with the ingress port. A frame that misses in the lookup is flooded to every port outside the ingress port's own trunk. A second configuration bit selects whether control frames are recognised by the type field alone or by the type field together with the reserved destination address.

Top module: `frame_fwd_filter`

## Requirements
- R1: After reset, fwd_valid, drop, fwd_mask and drop_reason are all 0. Each frame_end produces a fwd_valid pulse exactly one cycle later, carrying that frame's decision. In cycles without a decision, fwd_valid is 0 and the mask, drop and reason outputs keep their last values.
- R2: A frame with crc_ok = 0 is dropped with reason code 1.
- R3: A frame shorter than 64 bytes or longer than the maximum is dropped with reason code 2. The maximum is 1518 when cfg_long_max = 0 and 1522 when cfg_long_max = 1, and both ends of the range are inclusive.
- R4: A frame with type 0x8808 is a control frame and is dropped with reason code 3. When cfg_type_only = 0, the frame is a control frame only if dst_mac is also 48'h0180C2000001. When cfg_type_only = 1, the type field alone decides.
- R5: A frame that hits in the lookup with lkp_port equal to src_port is dropped with reason code 4.
- R6: trunk_grp holds a 2-bit group id for each port, with port p at bits [2p+1:2p] and 0 meaning the port is in no trunk. A frame that hits on a different port with the same nonzero id as src_port is dropped with reason code 5.
- R7: A frame that hits and is not dropped is forwarded with a mask in which only bit lkp_port is set.
- R8: A frame that misses is flooded to every port except src_port and the ports that share its nonzero trunk id. If that mask is empty, the frame is dropped with reason code 6.
- R9: When several drop rules apply, the smallest reason code is reported.
- R10: A dropped frame carries an all-zero mask. A forwarded frame carries reason code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_end | input | 1 | Frame status is valid; requests a decision |
| crc_ok | input | 1 | Frame CRC was correct |
| frame_len | input | 14 | Frame length in bytes |
| src_port | input | 3 | Ingress port number |
| lkp_hit | input | 1 | Destination address found in lookup |
| lkp_port | input | 3 | Port returned by the lookup |
| ether_type | input | 16 | Type/length field of the frame |
| dst_mac | input | 48 | Destination MAC address |
| trunk_grp | input | 10 | 2-bit trunk id per port, 0 = none |
| cfg_long_max | input | 1 | 0: maximum 1518 bytes, 1: maximum 1522 bytes |
| cfg_type_only | input | 1 | 1: control frames recognised by type field only |
| fwd_valid | output | 1 | Decision valid pulse |
| fwd_mask | output | 5 | Destination port mask |
| drop | output | 1 | Frame is discarded |
| drop_reason | output | 3 | Drop reason code |

## Verification
The hardest cases to reach are a flood whose mask comes out empty and frames that break several rules at once. The bench reaches the empty flood by putting all five ports into a single trunk id and sending a lookup miss. It reaches the overlaps by combining a bad CRC, an illegal length, a control type and a local hit in the same frame. It sweeps every ingress port, every lookup port and both hit states under four trunk maps. It also sweeps the length limits and the control-recognition cases under both settings of each configuration bit.

// File: rtl/fwd_filter_pkg.sv
package fwd_filter_pkg;
  typedef enum logic [2:0] {
    RSN_NONE  = 3'd0,
    RSN_CRC   = 3'd1,
    RSN_LEN   = 3'd2,
    RSN_CTRL  = 3'd3,
    RSN_LOCAL = 3'd4,
    RSN_TRUNK = 3'd5,
    RSN_EMPTY = 3'd6
  } drop_rsn_e;

  localparam int unsigned MIN_LEN       = 64;
  localparam int unsigned MAX_LEN_SHORT = 1518;
  localparam int unsigned MAX_LEN_LONG  = 1522;
  localparam logic [15:0] CTRL_TYPE     = 16'h8808;
  localparam logic [47:0] CTRL_DA       = 48'h0180C2000001;
endpackage

// File: rtl/frame_qualifier.sv
module frame_qualifier
  import fwd_filter_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             crc_ok,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             cfg_long_max,
  input  logic             cfg_type_only,
  input  logic [15:0]      ether_type,
  input  logic [47:0]      dst_mac,
  output logic             crc_bad,
  output logic             len_bad,
  output logic             is_ctrl
);
  localparam logic [LEN_W-1:0] LMIN   = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] LSHORT = LEN_W'(MAX_LEN_SHORT);
  localparam logic [LEN_W-1:0] LLONG  = LEN_W'(MAX_LEN_LONG);

  logic [LEN_W-1:0] len_max;
  logic             type_match;
  logic             da_match;

  always_comb begin
    len_max    = cfg_long_max ? LLONG : LSHORT;
    crc_bad    = !crc_ok;
    len_bad    = (frame_len < LMIN) || (frame_len > len_max);
    type_match = (ether_type == CTRL_TYPE);
    da_match   = (dst_mac == CTRL_DA);
    is_ctrl    = type_match && (cfg_type_only || da_match);
  end
endmodule

// File: rtl/port_mask_gen.sv
module port_mask_gen #(
  parameter int NPORTS = 5,
  parameter int PID_W  = 3,
  parameter int TG_W   = 2
) (
  input  logic [PID_W-1:0]       src_port,
  input  logic                   lkp_hit,
  input  logic [PID_W-1:0]       lkp_port,
  input  logic [NPORTS*TG_W-1:0] trunk_grp,
  output logic [NPORTS-1:0]      mask_c,
  output logic                   is_local,
  output logic                   same_trunk
);
  logic [TG_W-1:0]   grp [NPORTS];
  logic [TG_W-1:0]   src_grp;
  logic [TG_W-1:0]   lkp_grp;
  logic [NPORTS-1:0] excl;
  logic [NPORTS-1:0] uni;

  genvar gi;
  generate
    for (gi = 0; gi < NPORTS; gi++) begin : g_port
      assign grp[gi]  = trunk_grp[gi*TG_W +: TG_W];
      assign excl[gi] = (PID_W'(gi) == src_port) ||
                        ((src_grp != '0) && (grp[gi] == src_grp));
      assign uni[gi]  = (PID_W'(gi) == lkp_port);
    end
  endgenerate

  always_comb begin
    src_grp = '0;
    lkp_grp = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (PID_W'(p) == src_port) src_grp = grp[p];
      if (PID_W'(p) == lkp_port) lkp_grp = grp[p];
    end
    is_local   = (lkp_port == src_port);
    same_trunk = (src_grp != '0) && (lkp_grp == src_grp);
    mask_c     = lkp_hit ? uni : ~excl;
  end
endmodule

// File: rtl/frame_fwd_filter.sv
module frame_fwd_filter
  import fwd_filter_pkg::*;
#(
  parameter int NPORTS = 5,
  parameter int PID_W  = 3,
  parameter int TG_W   = 2,
  parameter int LEN_W  = 14
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   frame_end,
  input  logic                   crc_ok,
  input  logic [LEN_W-1:0]       frame_len,
  input  logic [PID_W-1:0]       src_port,
  input  logic                   lkp_hit,
  input  logic [PID_W-1:0]       lkp_port,
  input  logic [15:0]            ether_type,
  input  logic [47:0]            dst_mac,
  input  logic [NPORTS*TG_W-1:0] trunk_grp,
  input  logic                   cfg_long_max,
  input  logic                   cfg_type_only,
  output logic                   fwd_valid,
  output logic [NPORTS-1:0]      fwd_mask,
  output logic                   drop,
  output logic [2:0]             drop_reason
);
  logic              crc_bad, len_bad, is_ctrl;
  logic              is_local, same_trunk;
  logic [NPORTS-1:0] mask_c;
  drop_rsn_e         rsn_c;

  frame_qualifier #(.LEN_W(LEN_W)) qual_i (
    .crc_ok        (crc_ok),
    .frame_len     (frame_len),
    .cfg_long_max  (cfg_long_max),
    .cfg_type_only (cfg_type_only),
    .ether_type    (ether_type),
    .dst_mac       (dst_mac),
    .crc_bad       (crc_bad),
    .len_bad       (len_bad),
    .is_ctrl       (is_ctrl)
  );

  port_mask_gen #(.NPORTS(NPORTS), .PID_W(PID_W), .TG_W(TG_W)) mask_i (
    .src_port   (src_port),
    .lkp_hit    (lkp_hit),
    .lkp_port   (lkp_port),
    .trunk_grp  (trunk_grp),
    .mask_c     (mask_c),
    .is_local   (is_local),
    .same_trunk (same_trunk)
  );

  // Fixed priority: lower code wins.
  always_comb begin
    if (crc_bad)                      rsn_c = RSN_CRC;
    else if (len_bad)                 rsn_c = RSN_LEN;
    else if (is_ctrl)                 rsn_c = RSN_CTRL;
    else if (lkp_hit && is_local)     rsn_c = RSN_LOCAL;
    else if (lkp_hit && same_trunk)   rsn_c = RSN_TRUNK;
    else if (mask_c == '0)            rsn_c = RSN_EMPTY;
    else                              rsn_c = RSN_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid   <= 1'b0;
      fwd_mask    <= '0;
      drop        <= 1'b0;
      drop_reason <= 3'd0;
    end else begin
      fwd_valid <= frame_end;
      if (frame_end) begin
        drop        <= (rsn_c != RSN_NONE);
        drop_reason <= rsn_c;
        fwd_mask    <= (rsn_c != RSN_NONE) ? '0 : mask_c;
      end
    end
  end
endmodule

// File: rtl/fwd_filter_chk.sv
module fwd_filter_chk #(
  parameter int NPORTS = 5,
  parameter int PID_W  = 3,
  parameter int TG_W   = 2,
  parameter int LEN_W  = 14
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   frame_end,
  input logic                   crc_ok,
  input logic                   lkp_hit,
  input logic [PID_W-1:0]       src_port,
  input logic                   fwd_valid,
  input logic [NPORTS-1:0]      fwd_mask,
  input logic                   drop,
  input logic [2:0]             drop_reason
);
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> fwd_valid);
  p_hold_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> (!fwd_valid && $stable(fwd_mask) && $stable(drop_reason)));
  p_crc_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (frame_end && !crc_ok) |=> (drop && drop_reason == 3'd1));
  p_hit_single_r7: assert property (@(posedge clk) disable iff (rst)
    (frame_end && lkp_hit) |=> ($countones(fwd_mask) <= 1));
  p_no_self_r8: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (fwd_mask[$past(src_port)] == 1'b0));
  p_drop_empty_r10: assert property (@(posedge clk) disable iff (rst)
    (fwd_valid && drop) |-> (fwd_mask == '0 && drop_reason != 3'd0));
  p_fwd_clean_r10: assert property (@(posedge clk) disable iff (rst)
    (fwd_valid && !drop) |-> (drop_reason == 3'd0 && fwd_mask != '0));
endmodule

bind frame_fwd_filter fwd_filter_chk #(
  .NPORTS(NPORTS), .PID_W(PID_W), .TG_W(TG_W), .LEN_W(LEN_W)
) chk_i (.*);

// File: tb/frame_fwd_filter_tb_top.sv
module frame_fwd_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_end = 1'b0;
  logic        crc_ok = 1'b1;
  logic [13:0] frame_len = 14'd100;
  logic [2:0]  src_port = 3'd0;
  logic        lkp_hit = 1'b0;
  logic [2:0]  lkp_port = 3'd0;
  logic [15:0] ether_type = 16'h0800;
  logic [47:0] dst_mac = 48'h001122334455;
  logic [9:0]  trunk_grp = 10'd0;
  logic        cfg_long_max = 1'b0;
  logic        cfg_type_only = 1'b0;
  logic        fwd_valid;
  logic [4:0]  fwd_mask;
  logic        drop;
  logic [2:0]  drop_reason;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  frame_fwd_filter dut_i (
    .clk(clk), .rst(rst), .frame_end(frame_end), .crc_ok(crc_ok),
    .frame_len(frame_len), .src_port(src_port), .lkp_hit(lkp_hit),
    .lkp_port(lkp_port), .ether_type(ether_type), .dst_mac(dst_mac),
    .trunk_grp(trunk_grp), .cfg_long_max(cfg_long_max),
    .cfg_type_only(cfg_type_only), .fwd_valid(fwd_valid),
    .fwd_mask(fwd_mask), .drop(drop), .drop_reason(drop_reason)
  );

  function automatic int grp_of(input int p);
    return int'((trunk_grp >> (2*p)) & 10'd3);
  endfunction

  function automatic void expect_of(output logic [4:0] m, output logic d,
                                    output logic [2:0] r);
    int lmax, sg;
    logic [4:0] cand;
    logic ctrl;
    lmax = cfg_long_max ? 1522 : 1518;
    sg   = grp_of(int'(src_port));
    ctrl = (ether_type == 16'h8808) &&
           (cfg_type_only || dst_mac == 48'h0180C2000001);
    cand = 5'd0;
    for (int p = 0; p < 5; p++)
      if (p != int'(src_port) && !(sg != 0 && grp_of(p) == sg)) cand[p] = 1'b1;
    if (lkp_hit) cand = 5'd1 << lkp_port;
    if (!crc_ok) r = 3'd1;
    else if (int'(frame_len) < 64 || int'(frame_len) > lmax) r = 3'd2;
    else if (ctrl) r = 3'd3;
    else if (lkp_hit && lkp_port == src_port) r = 3'd4;
    else if (lkp_hit && sg != 0 && grp_of(int'(lkp_port)) == sg) r = 3'd5;
    else if (cand == 5'd0) r = 3'd6;
    else r = 3'd0;
    d = (r != 3'd0);
    m = d ? 5'd0 : cand;
  endfunction

  task automatic check(input string req, input logic ok, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input string req);
    logic [4:0] em;
    logic ed;
    logic [2:0] er;
    expect_of(em, ed, er);
    @(negedge clk) frame_end = 1'b1;
    @(negedge clk) frame_end = 1'b0;
    check(req, fwd_valid === 1'b1 && fwd_mask === em && drop === ed &&
          drop_reason === er, "decision",
          {fwd_valid, 3'b0, 3'b0, fwd_mask, drop, drop_reason},
          {1'b1, 3'b0, 3'b0, em, ed, er});
  endtask

  task automatic defaults();
    crc_ok = 1'b1; frame_len = 14'd100; src_port = 3'd0; lkp_hit = 1'b0;
    lkp_port = 3'd0; ether_type = 16'h0800; dst_mac = 48'h001122334455;
    trunk_grp = 10'd0; cfg_long_max = 1'b0; cfg_type_only = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [9:0] tmaps [4];
    int lens [12];
    logic [4:0] held;
    tmaps[0] = 10'b00_00_00_00_00;
    tmaps[1] = 10'b00_00_00_01_01;
    tmaps[2] = 10'b00_10_10_01_01;
    tmaps[3] = 10'b01_01_01_01_01;
    lens = '{0, 63, 64, 65, 1000, 1517, 1518, 1519, 1521, 1522, 1523, 16383};

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", fwd_valid === 1'b0 && fwd_mask === 5'd0 && drop === 1'b0 &&
          drop_reason === 3'd0, "reset",
          {7'b0, fwd_valid, fwd_mask, drop, drop_reason}, 16'h0);
    rst = 1'b0;
    @(negedge clk);

    // R5 R6 R7 R8: port sweep over trunk maps
    for (int t = 0; t < 4; t++)
      for (int s = 0; s < 5; s++)
        for (int h = 0; h < 2; h++)
          for (int l = 0; l < 5; l++) begin
            defaults();
            trunk_grp = tmaps[t]; src_port = 3'(s);
            lkp_hit = h[0]; lkp_port = 3'(l);
            run_frame(h != 0 ? "R5_R6_R7" : "R8");
          end

    // R1: outputs hold while idle
    held = fwd_mask;
    repeat (3) @(negedge clk);
    check("R1", fwd_valid === 1'b0 && fwd_mask === held, "hold",
          {11'b0, fwd_mask}, {11'b0, held});

    // R2: bad CRC
    defaults(); crc_ok = 1'b0; lkp_hit = 1'b1; lkp_port = 3'd2;
    run_frame("R2");

    // R3: length limits under both maxima
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 12; i++) begin
        defaults(); cfg_long_max = c[0]; frame_len = 14'(lens[i]);
        run_frame("R3");
      end

    // R4: control recognition modes
    for (int c = 0; c < 2; c++)
      for (int ty = 0; ty < 2; ty++)
        for (int da = 0; da < 2; da++) begin
          defaults(); cfg_type_only = c[0];
          ether_type = ty != 0 ? 16'h8808 : 16'h0800;
          dst_mac = da != 0 ? 48'h0180C2000001 : 48'h0180C2000002;
          run_frame("R4");
        end

    // R9: overlapping rule violations
    defaults(); crc_ok = 1'b0; frame_len = 14'd20; ether_type = 16'h8808;
    cfg_type_only = 1'b1; run_frame("R9");
    defaults(); frame_len = 14'd2000; ether_type = 16'h8808;
    cfg_type_only = 1'b1; lkp_hit = 1'b1; run_frame("R9");
    defaults(); ether_type = 16'h8808; cfg_type_only = 1'b1;
    lkp_hit = 1'b1; lkp_port = 3'd0; run_frame("R9");
    defaults(); trunk_grp = tmaps[3]; lkp_hit = 1'b1; lkp_port = 3'd0;
    run_frame("R9");

    // R10: back-to-back frames, drop then forward
    defaults(); crc_ok = 1'b0; run_frame("R10");
    defaults(); lkp_hit = 1'b1; lkp_port = 3'd4; run_frame("R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule